// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Event Code

This block gathers interrupt requests from four external request pins and from a parameterized set of peripheral sources. Each source carries a programmable 4-bit priority. The block picks the highest-priority request and compares it against the CPU's current mask level and a global block bit. It then raises an accept signal, together with an event code that identifies the winning source. Software uses that code as a branch offset instead of fetching a per-source vector.

A control bit selects how the four external pins are used. In encoded mode they carry one active-low 4-bit level, and that level competes directly as a priority. In independent mode each pin is its own active-low request, with a priority field of its own.

Acceptance takes two steps. In the first cycle a request is recognized. In the next cycle it is accepted. If the request has gone away by the acceptance cycle, the accept is still given, but it reports event code 0 and never a stale code. Accept is then held until the CPU acknowledges it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `int_accept` is 0, `event_code` is 0, the control register reads 0 and every priority register reads 0.
- R2: The register map is as follows. Address 0 is control, with bit 0 as the independent-pin mode bit. Address 1 holds the pin priorities, with pin j in bits 4j+3..4j. Address 2+k holds the peripheral priorities for sources 4k..4k+3, with source i in bits 4(i mod 4)+3..4(i mod 4). Unmapped addresses read 0. A write is applied at the clock edge where `reg_wr` is sampled high. Arbitration first uses the new value at the edge after that one.
- R3: In encoded mode (mode bit 0), the priority level is the bitwise inverse of `ext_req_n`. When all pins are high, the level is 0 and there is no request. A nonzero level L reports event code 0x200 + 32·L.
- R4: In independent mode (mode bit 1), pin j requests while it is low, at the priority held in its field. Its event code is 0x400 + 32·j.
- R5: Peripheral source i requests while `periph_req[i]` is 1, at its programmed priority. Its event code is 0x500 + 32·i. A priority of 0 disables any source.
- R6: A request is accepted only when its priority is strictly greater than `cpu_mask`.
- R7: The highest priority wins. On a tie, the lowest source index wins, and the pins (indices 0–3) rank ahead of the peripherals (indices 4 and up).
- R8: No request is accepted while `cpu_block` is 1. A request that is still pending is accepted once `cpu_block` returns to 0.
- R9: Suppose a qualifying request is first seen at edge E0 while the block is idle. Then `int_accept` rises at edge E1, and `event_code` is loaded at that same edge. Accept stays high until `int_ack` is sampled high, and drops at that edge. `event_code` keeps its value until the next acceptance.
- R10: Suppose a request was recognized at E0 but no qualifying request remains at E1. The acceptance still happens, and it reports `event_code` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| ext_req_n | input | 4 | External request pins, active low |
| periph_req | input | NUM_PERIPH | Peripheral request lines, active high |
| cpu_mask | input | 4 | CPU interrupt mask level |
| cpu_block | input | 1 | CPU global block bit; 1 blocks acceptance |
| int_ack | input | 1 | Acknowledge of a held accept |
| int_accept | output | 1 | Interrupt accepted, held until acknowledged |
| event_code | output | 12 | Code of the accepted source, 0 for a vanished request |

## Verification
The assertions take `cpu_mask`, `cpu_block`, the request lines and the register port to be synchronous to `clk`, so each of them holds one value per cycle. They also take `int_ack` to be meaningful only while `int_accept` is high. The bench changes every input only at the falling edge. It raises `int_ack` only to retire an accept it has already checked, and it clears all requests in that same cycle, so that no extra recognition can follow. Mask and block levels are changed only between scenarios, or deliberately while a request waits, to exercise R6 and R8.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PRIO_W   = 4;
    localparam int CODE_W   = 12;
    localparam int REG_W    = 16;
    localparam int FPR      = REG_W / PRIO_W;
    localparam int NUM_PINS = 4;
    localparam int CODE_SH  = 5;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_PINPRIO = 1;
    localparam int ADDR_PER0    = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t LVL_BASE = 12'h200;
    localparam code_t PIN_BASE = 12'h400;
    localparam code_t PER_BASE = 12'h500;

    typedef struct packed {
        logic  req;
        prio_t prio;
        code_t code;
    } src_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_SEEN,
        ACC_HELD
    } acc_state_e;

    function automatic code_t level_code(input prio_t lvl);
        return LVL_BASE + (code_t'(lvl) << CODE_SH);
    endfunction

    function automatic code_t pin_code(input int j);
        return PIN_BASE + (code_t'(j) << CODE_SH);
    endfunction

    function automatic code_t per_code(input int i);
        return PER_BASE + (code_t'(i) << CODE_SH);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              indep_mode,
    output prio_t             pin_prio [NUM_PINS],
    output prio_t             per_prio [NUM_PERIPH]
);

    localparam int NPR = (NUM_PERIPH + FPR - 1) / FPR;

    logic             ctrl_q;
    logic [REG_W-1:0] pin_q;
    logic [REG_W-1:0] per_q [NPR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
            pin_q  <= '0;
            for (int k = 0; k < NPR; k++) per_q[k] <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(ADDR_CTRL))    ctrl_q <= wdata[0];
            if (addr == ADDR_W'(ADDR_PINPRIO)) pin_q  <= wdata;
            for (int k = 0; k < NPR; k++)
                if (addr == ADDR_W'(ADDR_PER0 + k)) per_q[k] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))    rdata = REG_W'(ctrl_q);
        if (addr == ADDR_W'(ADDR_PINPRIO)) rdata = pin_q;
        for (int k = 0; k < NPR; k++)
            if (addr == ADDR_W'(ADDR_PER0 + k)) rdata = per_q[k];
    end

    assign indep_mode = ctrl_q;

    for (genvar j = 0; j < NUM_PINS; j++) begin : g_pin
        assign pin_prio[j] = pin_q[j*PRIO_W +: PRIO_W];
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        assign per_prio[i] = per_q[i/FPR][(i%FPR)*PRIO_W +: PRIO_W];
    end

    // A write lands in the register at the edge that samples it (R2)
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == ADDR_W'(ADDR_PINPRIO)) |=> (pin_q == $past(wdata)));

endmodule

// File: rtl/irqc_sources.sv
module irqc_sources
    import irqc_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    localparam int NS        = NUM_PINS + NUM_PERIPH
) (
    input  logic                  indep_mode,
    input  logic [NUM_PINS-1:0]   ext_req_n,
    input  prio_t                 pin_prio [NUM_PINS],
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  prio_t                 per_prio [NUM_PERIPH],
    output src_t                  srcs [NS]
);

    prio_t enc_level;
    assign enc_level = prio_t'(~ext_req_n);

    always_comb begin
        for (int j = 0; j < NUM_PINS; j++) begin
            srcs[j].req  = indep_mode & ~ext_req_n[j];
            srcs[j].prio = pin_prio[j];
            srcs[j].code = pin_code(j);
        end
        if (!indep_mode) begin
            srcs[0].req  = (enc_level != '0);
            srcs[0].prio = enc_level;
            srcs[0].code = level_code(enc_level);
        end
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        assign srcs[NUM_PINS+i].req  = periph_req[i];
        assign srcs[NUM_PINS+i].prio = per_prio[i];
        assign srcs[NUM_PINS+i].code = per_code(i);
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NS = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  src_t  srcs [NS],
    output logic  win_any,
    output prio_t win_prio,
    output code_t win_code
);

    always_comb begin
        win_any  = 1'b0;
        win_prio = '0;
        win_code = '0;
        for (int i = 0; i < NS; i++) begin
            if (srcs[i].req && srcs[i].prio > win_prio) begin
                win_any  = 1'b1;
                win_prio = srcs[i].prio;
                win_code = srcs[i].code;
            end
        end
    end

    for (genvar i = 0; i < NS; i++) begin : g_chk
        // No live request outranks the reported winner (R7)
        assert_max_prio_R7: assert property (@(posedge clk) disable iff (rst)
            srcs[i].req |-> (srcs[i].prio <= win_prio));
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_PINS-1:0]   ext_req_n,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic [PRIO_W-1:0]     cpu_mask,
    input  logic                  cpu_block,
    input  logic                  int_ack,
    output logic                  int_accept,
    output logic [CODE_W-1:0]     event_code
);

    localparam int NS = NUM_PINS + NUM_PERIPH;

    logic       indep_mode;
    prio_t      pin_prio [NUM_PINS];
    prio_t      per_prio [NUM_PERIPH];
    src_t       srcs [NS];
    logic       win_any;
    prio_t      win_prio;
    code_t      win_code;
    logic       cand;
    acc_state_e state_q;
    code_t      code_q;

    irqc_regs #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .indep_mode (indep_mode),
        .pin_prio   (pin_prio),
        .per_prio   (per_prio)
    );

    irqc_sources #(.NUM_PERIPH(NUM_PERIPH)) u_src (
        .indep_mode (indep_mode),
        .ext_req_n  (ext_req_n),
        .pin_prio   (pin_prio),
        .periph_req (periph_req),
        .per_prio   (per_prio),
        .srcs       (srcs)
    );

    irqc_arbiter #(.NS(NS)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .srcs     (srcs),
        .win_any  (win_any),
        .win_prio (win_prio),
        .win_code (win_code)
    );

    assign cand = win_any && (win_prio > cpu_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
            code_q  <= '0;
        end else begin
            unique case (state_q)
                ACC_IDLE: if (cand && !cpu_block) state_q <= ACC_SEEN;
                ACC_SEEN: begin
                    if (cpu_block) begin
                        state_q <= ACC_IDLE;
                    end else begin
                        state_q <= ACC_HELD;
                        code_q  <= cand ? win_code : '0;
                    end
                end
                ACC_HELD: if (int_ack) state_q <= ACC_IDLE;
                default:  state_q <= ACC_IDLE;
            endcase
        end
    end

    assign int_accept = (state_q == ACC_HELD);
    assign event_code = code_q;

    assert_block_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(int_accept) |-> !$past(cpu_block));

    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(int_accept) && event_code != '0) |-> ($past(win_prio) > $past(cpu_mask)));

    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (int_accept && !int_ack) |=> int_accept);

    assert_code_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !$rose(int_accept) |-> $stable(event_code));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [3:0]  ext_req_n;
    logic [NP-1:0] periph_req;
    logic [3:0]  cpu_mask;
    logic        cpu_block;
    logic        int_ack;
    logic        int_accept;
    logic [11:0] event_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl #(.NUM_PERIPH(NP), .ADDR_W(4)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req_n(ext_req_n),
        .periph_req(periph_req), .cpu_mask(cpu_mask), .cpu_block(cpu_block),
        .int_ack(int_ack), .int_accept(int_accept), .event_code(event_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic two_edges();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic retire();
        ext_req_n = 4'hF; periph_req = '0; int_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        int_ack = 1'b0;
        idle(1);
    endtask

    task automatic t_reset();
        check("R1 accept after reset", int_accept, 0);
        check("R1 code after reset", event_code, 0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 4'(a); #1;
            check("R1 register reset value", reg_rdata, 0);
        end
    endtask

    task automatic t_regs();
        wr_reg(4'd1, 16'h1234);
        reg_addr = 4'd1; #1; check("R2 pin priority readback", reg_rdata, 16'h1234);
        wr_reg(4'd3, 16'hA5C3);
        reg_addr = 4'd3; #1; check("R2 peripheral register readback", reg_rdata, 16'hA5C3);
        reg_addr = 4'd15; #1; check("R2 unmapped address", reg_rdata, 0);
        wr_reg(4'd0, 16'hFFFE);
        reg_addr = 4'd0; #1; check("R2 control bit 0 only", reg_rdata, 0);
        wr_reg(4'd1, 16'h0000);
        wr_reg(4'd3, 16'h0000);
        // new priority counts only after the write edge
        periph_req = 8'h20;
        reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 16'h0030;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 no accept before write is used", int_accept, 0);
        @(posedge clk); @(negedge clk);
        check("R2 accept with new priority", int_accept, 1);
        check("R2 code source 5", event_code, 12'h5A0);
        retire();
        wr_reg(4'd3, 16'h0000);
    endtask

    task automatic t_encoded();
        wr_reg(4'd0, 16'h0000);
        ext_req_n = ~4'd9;
        two_edges();
        check("R3 encoded accept", int_accept, 1);
        check("R3 encoded code level 9", event_code, 12'h200 + 9*32);
        retire();
        ext_req_n = 4'hF;
        idle(4);
        check("R3 all high means no request", int_accept, 0);
    endtask

    task automatic t_indep();
        wr_reg(4'd0, 16'h0001);
        wr_reg(4'd1, 16'h1234);
        ext_req_n = 4'b1011;
        two_edges();
        check("R4 pin 2 accept", int_accept, 1);
        check("R4 pin 2 code", event_code, 12'h440);
        retire();
        ext_req_n = 4'b0101;
        two_edges();
        check("R4 pin 1 over pin 3 code", event_code, 12'h420);
        retire();
    endtask

    task automatic t_periph();
        wr_reg(4'd2, 16'h0070);
        periph_req = 8'h03;
        two_edges();
        check("R5 peripheral 1 code", event_code, 12'h520);
        retire();
        periph_req = 8'h01;
        idle(4);
        check("R5 priority zero disabled", int_accept, 0);
        periph_req = 8'h00;
    endtask

    task automatic t_mask();
        cpu_mask = 4'd7;
        periph_req = 8'h02;
        idle(4);
        check("R6 equal to mask rejected", int_accept, 0);
        cpu_mask = 4'd6;
        two_edges();
        check("R6 above mask accepted", int_accept, 1);
        check("R6 code", event_code, 12'h520);
        retire();
        cpu_mask = 4'd0;
    endtask

    task automatic t_tie();
        wr_reg(4'd1, 16'h0500);
        wr_reg(4'd2, 16'h5555);
        periph_req = 8'h0C;
        two_edges();
        check("R7 tie lower peripheral wins", event_code, 12'h540);
        retire();
        ext_req_n = 4'b1011; periph_req = 8'h01;
        two_edges();
        check("R7 pin ranks ahead of peripheral", event_code, 12'h440);
        retire();
        wr_reg(4'd3, 16'h000A);
        ext_req_n = 4'b1011; periph_req = 8'h10;
        two_edges();
        check("R7 higher priority wins", event_code, 12'h580);
        retire();
    endtask

    task automatic t_block();
        cpu_block = 1'b1;
        periph_req = 8'h04;
        idle(5);
        check("R8 blocked no accept", int_accept, 0);
        check("R8 blocked code unchanged", event_code, 12'h580);
        cpu_block = 1'b0;
        two_edges();
        check("R8 accepted after unblock", int_accept, 1);
        check("R8 code", event_code, 12'h540);
        retire();
    endtask

    task automatic t_latency();
        periph_req = 8'h08;
        @(posedge clk); @(negedge clk);
        check("R9 not accepted after first edge", int_accept, 0);
        @(posedge clk); @(negedge clk);
        check("R9 accepted after second edge", int_accept, 1);
        check("R9 code loaded", event_code, 12'h560);
        periph_req = 8'h00;
        idle(3);
        check("R9 held without ack", int_accept, 1);
        int_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        int_ack = 1'b0;
        check("R9 dropped after ack", int_accept, 0);
        idle(2);
        check("R9 code held", event_code, 12'h560);
    endtask

    task automatic t_spurious();
        periph_req = 8'h08;
        @(posedge clk); @(negedge clk);
        periph_req = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R10 vanished request accepted", int_accept, 1);
        check("R10 vanished request code zero", event_code, 0);
        retire();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        ext_req_n = 4'hF; periph_req = '0; cpu_mask = '0;
        cpu_block = 1'b0; int_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_encoded();
        t_indep();
        t_periph();
        t_mask();
        t_tie();
        t_block();
        t_latency();
        t_spurious();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule